// File: doc/BRIEF.md
# Receive Descriptor Occupancy Tracker

This block keeps the bookkeeping for a single receive descriptor ring of a network DMA engine. It holds two saturating counts. One is the number of descriptors that carry a received frame and wait for software (occupied). The other is the number of empty descriptors the hardware may still fill (free). It also holds the index of the descriptor the next incoming frame will use.

Software reaches the block through a small word-indexed register port. A single write to the update register does two things at once: it retires processed descriptors from the occupied count and returns refilled descriptors to the free count. Other registers configure the ring length and buffer size, enable or disable the queue, and hold the receive path in reset.

On the hardware side, each frame completion is offered on `frm_valid`. A frame is accepted when `frm_valid` and `frm_ready` are both high in the same cycle. An accepted frame takes the descriptor shown on `frm_desc_idx`, moves one descriptor from free to occupied, and advances the ring index.

The frame source cannot stall. Every cycle with `frm_valid` high is a separate frame, and one that meets `frm_ready` low is lost and reported on `drop_o`. `frm_ready` depends only on registered state, never on `frm_valid`.

Top module: `rxq_occupancy_tracker`

## Requirements
- R1: After `rst_n` is released, all of the following hold: the status word reads 0, the queue command word reads 0, `frm_ready` is low, and the path-reset bit is 0.
- R2: Reading register index 0 (status) returns the occupied count in bits [13:0], the free count in bits [29:16], and the sticky bound-error flag in bit 31. Writes to index 0 have no effect.
- R3: A write to index 1 (update) subtracts bits [13:0] from the occupied count and adds bits [23:16] (at most 255) to the free count, both in the same cycle.
- R4: Index 2 (size) holds the ring length in descriptors in bits [13:0] and the buffer size in 8-byte units in bits [31:19]. Both fields read back in place.
- R5: At index 3 (queue command), a 1 in bit QID of [7:0] enables the queue and a 1 in bit 8+QID of [15:8] disables it. Disable wins when both are set, and bits for other queues are ignored. A read returns the enable state in bit QID.
- R6: `frm_ready` is high exactly when the queue is enabled, the path is not in reset, and the free count is nonzero. Each accepted frame decrements free by one and increments occupied by one.
- R7: A cycle with `frm_valid` high and `frm_ready` low raises `drop_o` for the following cycle and changes no count.
- R8: `frm_desc_idx` starts at 0, advances by one per accepted frame, and wraps to 0 after index ring length − 1.
- R9: An update write in the same cycle as an accepted frame applies both changes, with neither one lost.
- R10: Both counts saturate at 0 and at the ring length. Any attempt to pass either bound sets the bound-error flag, which stays set until a path reset.
- R11: While bit 0 of index 4 (path reset) is 1, the following all apply: both counts, the ring index and the error flag are cleared; update writes are ignored; and `frm_ready` is low. Writing 0 releases the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| frm_valid | input | 1 | A frame has completed and needs a descriptor |
| frm_ready | output | 1 | A descriptor is available for the offered frame |
| frm_desc_idx | output | CNT_W | Ring index the next accepted frame uses |
| drop_o | output | 1 | One-cycle pulse after a refused frame |

## Verification
The assertions take for granted three things about the inputs:
- the frame source never waits on `frm_ready`;
- the ring length is not rewritten in the same cycle as an accepted frame;
- the counts are only ever driven past their bounds through the saturating paths.

The stimulus keeps within these assumptions. It changes the size register only while no frame is offered. It produces bound crossings only by deliberate over-retire and over-refill writes, or by shrinking the ring across a path reset. The bench predicts every count, index and drop pulse from an arithmetic model. It sweeps ring lengths 1 to 5 with more frames than descriptors, so every wrap and every refusal is visited.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // register word indices
  localparam logic [2:0] RA_STATUS = 3'd0;
  localparam logic [2:0] RA_UPDATE = 3'd1;
  localparam logic [2:0] RA_SIZE   = 3'd2;
  localparam logic [2:0] RA_QCMD   = 3'd3;
  localparam logic [2:0] RA_PRST   = 3'd4;

  // field positions
  localparam int UPD_ADD_LSB   = 16;
  localparam int SIZE_BUF_LSB  = 19;
  localparam int QCMD_DIS_LSB  = 8;
  localparam int STAT_FREE_LSB = 16;
  localparam int STAT_ERR_BIT  = 31;

  // counter slots in the counter array
  localparam int SLOT_OCC  = 0;
  localparam int SLOT_FREE = 1;
  localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/rxq_cfg_regs.sv
module rxq_cfg_regs
  import rxq_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int QID      = 0,
  parameter int REFILL_W = 8,
  parameter int BUF_W    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [CNT_W-1:0]    ring_len,
  output logic [BUF_W-1:0]    buf_units,
  output logic                q_en,
  output logic                path_rst,
  output logic                upd_wr,
  output logic [CNT_W-1:0]    upd_ret,
  output logic [REFILL_W-1:0] upd_add
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_len  <= '0;
      buf_units <= '0;
      q_en      <= 1'b0;
      path_rst  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_SIZE: begin
          ring_len  <= reg_wdata[CNT_W-1:0];
          buf_units <= reg_wdata[SIZE_BUF_LSB +: BUF_W];
        end
        RA_QCMD: begin
          if (reg_wdata[QCMD_DIS_LSB + QID])
            q_en <= 1'b0;
          else if (reg_wdata[QID])
            q_en <= 1'b1;
        end
        RA_PRST: path_rst <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assign upd_wr  = reg_wr && (reg_addr == RA_UPDATE) && !path_rst;
  assign upd_ret = reg_wdata[CNT_W-1:0];
  assign upd_add = reg_wdata[UPD_ADD_LSB +: REFILL_W];
endmodule

// File: rtl/rxq_sat_cnt.sv
module rxq_sat_cnt #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] add_amt,
  input  logic [W-1:0] sub_amt,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         bound_hit
);
  logic [W:0]   sum;
  logic [W:0]   diff;
  logic [W-1:0] nxt;

  always_comb begin
    sum       = {1'b0, cnt} + {1'b0, add_amt};
    diff      = sum - {1'b0, sub_amt};
    nxt       = diff[W-1:0];
    bound_hit = 1'b0;
    if ({1'b0, sub_amt} > sum) begin
      nxt       = '0;
      bound_hit = 1'b1;
    end else if (diff > {1'b0, limit}) begin
      nxt       = limit;
      bound_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= nxt;
  end
endmodule

// File: rtl/rxq_ring_ptr.sv
module rxq_ring_ptr #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] ring_len,
  output logic [W-1:0] idx
);
  logic [W:0] inc;
  assign inc = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= (inc >= {1'b0, ring_len}) ? '0 : inc[W-1:0];
  end
endmodule

// File: rtl/rxq_occupancy_tracker.sv
module rxq_occupancy_tracker
  import rxq_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int QID      = 0,
  parameter int REFILL_W = 8,
  parameter int BUF_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             frm_valid,
  output logic             frm_ready,
  output logic [CNT_W-1:0] frm_desc_idx,
  output logic             drop_o
);
  localparam int PAD_ADD = CNT_W - REFILL_W;

  logic [CNT_W-1:0]    ring_len;
  logic [BUF_W-1:0]    buf_units;
  logic                q_en;
  logic                path_rst;
  logic                upd_wr;
  logic [CNT_W-1:0]    upd_ret;
  logic [REFILL_W-1:0] upd_add;
  logic                take;
  logic                bound_err;

  logic [CNT_W-1:0] cnt_add [NUM_SLOTS];
  logic [CNT_W-1:0] cnt_sub [NUM_SLOTS];
  logic [CNT_W-1:0] cnt_val [NUM_SLOTS];
  logic             cnt_hit [NUM_SLOTS];
  logic [CNT_W-1:0] occ_cnt;
  logic [CNT_W-1:0] free_cnt;

  rxq_cfg_regs #(
    .CNT_W(CNT_W), .QID(QID), .REFILL_W(REFILL_W), .BUF_W(BUF_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ring_len(ring_len), .buf_units(buf_units),
    .q_en(q_en), .path_rst(path_rst), .upd_wr(upd_wr),
    .upd_ret(upd_ret), .upd_add(upd_add)
  );

  assign occ_cnt   = cnt_val[SLOT_OCC];
  assign free_cnt  = cnt_val[SLOT_FREE];
  assign frm_ready = q_en && !path_rst && (free_cnt != '0);
  assign take      = frm_valid && frm_ready;

  // occupied: gains the accepted frame, loses retired descriptors
  assign cnt_add[SLOT_OCC]  = {{(CNT_W-1){1'b0}}, take};
  assign cnt_sub[SLOT_OCC]  = upd_wr ? upd_ret : '0;
  // free: gains refilled descriptors, loses the accepted frame
  assign cnt_add[SLOT_FREE] = upd_wr ? {{PAD_ADD{1'b0}}, upd_add} : '0;
  assign cnt_sub[SLOT_FREE] = {{(CNT_W-1){1'b0}}, take};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cnt
    rxq_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(path_rst),
      .add_amt(cnt_add[g]), .sub_amt(cnt_sub[g]), .limit(ring_len),
      .cnt(cnt_val[g]), .bound_hit(cnt_hit[g])
    );
  end

  rxq_ring_ptr #(.W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(path_rst), .adv(take),
    .ring_len(ring_len), .idx(frm_desc_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_err <= 1'b0;
      drop_o    <= 1'b0;
    end else begin
      drop_o <= frm_valid && !frm_ready;
      if (path_rst)
        bound_err <= 1'b0;
      else if (cnt_hit[SLOT_OCC] || cnt_hit[SLOT_FREE])
        bound_err <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STATUS: begin
        reg_rdata[CNT_W-1:0]              = occ_cnt;
        reg_rdata[STAT_FREE_LSB +: CNT_W] = free_cnt;
        reg_rdata[STAT_ERR_BIT]           = bound_err;
      end
      RA_SIZE: begin
        reg_rdata[CNT_W-1:0]             = ring_len;
        reg_rdata[SIZE_BUF_LSB +: BUF_W] = buf_units;
      end
      RA_QCMD: reg_rdata[QID] = q_en;
      RA_PRST: reg_rdata[0]   = path_rst;
      default: ;
    endcase
  end
endmodule

// File: rtl/rxq_tracker_checker.sv
module rxq_tracker_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic             drop_o,
  input logic             upd_wr,
  input logic             path_rst,
  input logic             bound_err,
  input logic [CNT_W-1:0] ring_len,
  input logic [CNT_W-1:0] occ_cnt,
  input logic [CNT_W-1:0] free_cnt,
  input logic [CNT_W-1:0] frm_desc_idx
);
  p_accept_takes_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !reg_wr && (free_cnt <= ring_len))
      |=> (free_cnt == $past(free_cnt) - 1'b1));

  p_drop_follows_refusal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> drop_o);

  p_refusal_keeps_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready && !upd_wr && !path_rst && !reg_wr)
      |=> ($stable(occ_cnt) && $stable(free_cnt)));

  p_index_wraps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && (frm_desc_idx == ring_len - 1'b1))
      |=> (frm_desc_idx == '0));

  p_occ_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ_cnt != $past(occ_cnt)) && $stable(ring_len)) |-> (occ_cnt <= ring_len));

  p_free_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((free_cnt != $past(free_cnt)) && $stable(ring_len)) |-> (free_cnt <= ring_len));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_err && !path_rst) |=> bound_err);

  p_path_reset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    path_rst |=> ((occ_cnt == '0) && (free_cnt == '0) && (frm_desc_idx == '0) && !bound_err));

  p_no_ready_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    path_rst |-> !frm_ready);
endmodule

bind rxq_occupancy_tracker rxq_tracker_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .frm_valid(frm_valid),
  .frm_ready(frm_ready), .drop_o(drop_o), .upd_wr(upd_wr),
  .path_rst(path_rst), .bound_err(bound_err), .ring_len(ring_len),
  .occ_cnt(occ_cnt), .free_cnt(free_cnt), .frm_desc_idx(frm_desc_idx)
);

// File: tb/test_rxq_occupancy_tracker.sv
`timescale 1ns/1ps
module test_rxq_occupancy_tracker;
  localparam int CNT_W = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             frm_valid = 1'b0;
  logic             frm_ready;
  logic [CNT_W-1:0] frm_desc_idx;
  logic             drop_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the tracker
  int m_occ = 0, m_free = 0, m_ptr = 0, m_len = 0;
  bit m_err = 0, m_en = 0, m_prst = 0;

  always #2 clk = ~clk;  // 250 MHz

  rxq_occupancy_tracker #(.CNT_W(CNT_W)) i_rxq_occupancy_tracker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_desc_idx(frm_desc_idx), .drop_o(drop_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint stat_word();
    return (longint'(m_err) << 31) | (longint'(m_free) << 16) | longint'(m_occ);
  endfunction

  function automatic void model_clear();
    m_occ = 0; m_free = 0; m_ptr = 0; m_err = 0;
  endfunction

  // one stimulus cycle followed by one idle cycle in which results are checked
  task automatic step(input bit w, input logic [2:0] a, input logic [31:0] d,
                      input bit fv, input string tag);
    bit rdy;
    int take, ret, add, s;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; frm_valid = fv;
    #1;
    rdy = m_en && !m_prst && (m_free != 0);
    chk(frm_ready == rdy, "R6 ready", frm_ready, rdy);
    if (fv && rdy) chk(frm_desc_idx == m_ptr, "R8 index", frm_desc_idx, m_ptr);
    take = (fv && rdy) ? 1 : 0;
    ret = 0; add = 0;
    if (w && a == 3'd1 && !m_prst) begin ret = int'(d[13:0]); add = int'(d[23:16]); end
    if (m_prst) model_clear();
    else begin
      s = m_occ + take;
      if (ret > s) begin m_occ = 0; m_err = 1; end
      else if (s - ret > m_len) begin m_occ = m_len; m_err = 1; end
      else m_occ = s - ret;
      s = m_free + add;
      if (take > s) begin m_free = 0; m_err = 1; end
      else if (s - take > m_len) begin m_free = m_len; m_err = 1; end
      else m_free = s - take;
      if (take == 1) m_ptr = (m_ptr + 1 >= m_len) ? 0 : m_ptr + 1;
    end
    if (w && a == 3'd2) m_len = int'(d[13:0]);
    if (w && a == 3'd3) begin
      if (d[8]) m_en = 0;
      else if (d[0]) m_en = 1;
    end
    if (w && a == 3'd4) m_prst = d[0];
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; frm_valid = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    #1;
    chk(drop_o == (fv && !rdy), {"R7 drop ", tag}, drop_o, (fv && !rdy));
    chk(longint'(reg_rdata) == stat_word(), {"R2 status ", tag}, reg_rdata, stat_word());
    if (m_prst) model_clear();
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    #1;
    chk(frm_ready == 1'b0, "R1 ready", frm_ready, 0);
    rd(3'd0, 32'h0, "R1 status");
    rd(3'd3, 32'h0, "R1 qcmd");
    rd(3'd4, 32'h0, "R1 path reset");

    // R4: size register readback
    step(1, 3'd2, (32'd200 << 19) | 32'd4, 0, "R4");
    rd(3'd2, (32'd200 << 19) | 32'd4, "R4 size");
    // R2: status writes are ignored
    step(1, 3'd0, 32'hFFFF_FFFF, 0, "R2 write ignored");
    // R5: enable
    step(1, 3'd3, 32'h1, 0, "R5 enable");
    rd(3'd3, 32'h1, "R5 qcmd enabled");
    // R7: no free descriptors -> refused
    step(0, 3'd0, 0, 1, "R7 empty ring");
    // R3: refill
    step(1, 3'd1, 32'd4 << 16, 0, "R3 refill");
    // R6/R8: take more frames than descriptors
    for (int i = 0; i < 6; i++) step(0, 3'd0, 0, 1, "R6 frames");
    // R3: retire 2 and refill 3 in one write
    step(1, 3'd1, 32'd2 | (32'd3 << 16), 0, "R3 combined");
    // R9: update and frame in the same cycle
    step(1, 3'd1, 32'd1 | (32'd1 << 16), 1, "R9 concurrent");
    // R10: over-retire, then over-refill
    step(1, 3'd1, 32'd9, 0, "R10 underflow");
    step(1, 3'd1, 32'd255 << 16, 0, "R10 overflow");
    step(0, 3'd0, 0, 0, "R10 sticky");
    // R5: disable, both bits, other queue only
    step(1, 3'd3, 32'h100, 1, "R5 disable");
    rd(3'd3, 32'h0, "R5 qcmd disabled");
    step(1, 3'd3, 32'h101, 0, "R5 both bits");
    rd(3'd3, 32'h0, "R5 disable wins");
    step(1, 3'd3, 32'h2, 1, "R5 other queue");
    rd(3'd3, 32'h0, "R5 other queue ignored");
    step(1, 3'd3, 32'h1, 0, "R5 re-enable");
    // R11: path reset
    step(1, 3'd4, 32'h1, 0, "R11 assert");
    rd(3'd4, 32'h1, "R11 readback");
    step(1, 3'd1, 32'd3 << 16, 1, "R11 update ignored");
    step(1, 3'd4, 32'h0, 0, "R11 release");
    step(0, 3'd0, 0, 1, "R11 empty after release");

    // sweep of ring lengths: wrap and saturation for each
    for (int len = 1; len <= 5; len++) begin
      step(1, 3'd4, 32'h1, 0, "R11 sweep reset");
      step(1, 3'd4, 32'h0, 0, "R11 sweep release");
      step(1, 3'd2, 32'(len), 0, "R4 sweep size");
      step(1, 3'd1, 32'd255 << 16, 0, "R10 sweep fill");
      for (int k = 0; k < len + 2; k++) step(0, 3'd0, 0, 1, "R8 sweep frames");
      step(1, 3'd1, 32'(len) | (32'(len) << 16), 1, "R9 sweep concurrent");
      for (int k = 0; k < len + 1; k++) step(0, 3'd0, 0, 1, "R8 sweep wrap");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule